// File: doc/BRIEF.md
# Emergency Pin-Disable Request Detector

This block watches four active-low request inputs. Each input can trigger an emergency disable of a group of output pins. When an input's request is accepted, the block sets a sticky flag for that input. While any flag is set, the block drives a high-impedance request that downstream logic uses to float its pins. The same flags, gated by one enable bit, form a single interrupt request.

Each input has its own 2-bit mode.
- Mode 0 accepts a request on a falling edge.
- The other three modes use a low-level filter. It samples the input at the clock divided by 8, 16 or 128, and accepts a request only after 16 consecutive low samples.

Every input passes through a two-flop synchronizer before any detection.

Software uses one 16-bit register through a plain read strobe and a plain write strobe. Clearing a flag takes two steps: software must read the flag as 1 and then write 0 to it. In the filtered modes there is one more condition: the input must have been sampled high since that read.

Top module: `pin_disable_detect`

## Requirements
- R1: After reset, rdata reads 0 (all flags, modes and enable clear), and irq and hiz_req are low.
- R2: In mode 0, a falling edge on req_n[i] sets flag i, which reads at rdata bit 12+i. A rising edge sets nothing.
- R3: In modes 1, 2 and 3, flag i is set only after 16 consecutive low samples of req_n[i]. Samples are taken every 8, 16 or 128 clocks respectively. A low pulse shorter than 15 sample periods sets nothing.
- R4: A write of 0 to a set flag clears it only if the flag was read as 1 since the previous write. A write with no such read leaves the flag set, because every write consumes the armed read.
- R5: In modes 1 to 3, the clear of R4 also requires that the input was sampled high, at that mode's rate, after the read. Without this, the flag stays set.
- R6: Writing 1 to a flag bit leaves that flag unchanged.
- R7: hiz_req is high while any flag is set, whatever the enable. irq equals the enable bit (rdata bit 8) ANDed with the OR of the flags.
- R8: The mode for input i is at rdata bits 2i+1:2i and reads back as written, and so does the enable bit. Bits 11:9 always read 0 and ignore writes.
- R9: A request condition that is still present wins over a clear in the same cycle. A filtered input held low keeps its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the base of the sample dividers |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 4 | Active-low disable request inputs |
| rd_en | input | 1 | Register read strobe, arms the two-step clear |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data |
| irq | output | 1 | Interrupt request |
| hiz_req | output | 1 | High-impedance request for output pins |

## Verification
The bench sends filtered low pulses that are either well under 15 sample periods or past 17 sample periods. A design with the wrong divider or the wrong run length would then set flags it should not, or miss flags it should set.

It writes 0 with no prior read, and it writes 1 after a read. A design that ignored the read arming, or cleared on a written 1, would drop the flag. A design that let a 1 write leave the arm in place would clear the flag on the next write.

In the slowest filtered mode, it writes 0 right after the read and well away from a sample point. A design that skipped the high-sample condition would clear the flag at that write. It also clears an edge-mode flag while the input stays low, then raises the input, and checks that a rising edge does not set the flag again.

// File: rtl/pin_disable_detect.sv
module pin_disable_detect #(
  parameter int DIV_A   = 8,
  parameter int DIV_B   = 16,
  parameter int DIV_C   = 128,
  parameter int RUN_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  req_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq,
  output logic        hiz_req
);
  localparam int NIN = 4;
  localparam int PW  = $clog2(DIV_C);
  localparam int LA  = $clog2(DIV_A);
  localparam int LB  = $clog2(DIV_B);
  localparam int CW  = $clog2(RUN_LEN + 1);
  localparam int FB  = 12;
  localparam int EB  = 8;

  logic [PW-1:0]  pre;
  logic [2:0]     tick;
  logic [NIN-1:0] s1, s2, s3;
  logic [NIN-1:0] flag, armed, hi_seen;
  logic [7:0]     modes;
  logic           ie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  assign tick[0] = &pre[LA-1:0];
  assign tick[1] = &pre[LB-1:0];
  assign tick[2] = &pre;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= req_n;
      s2 <= s1;
      s3 <= s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      modes <= '0;
      ie    <= 1'b0;
    end else if (wr_en) begin
      modes <= wdata[7:0];
      ie    <= wdata[EB];
    end

  for (genvar i = 0; i < NIN; i++) begin : g_in
    logic [1:0]    md;
    logic          lvl, tk, hit, clr_ok;
    logic [CW-1:0] run;

    assign md  = modes[2*i +: 2];
    assign lvl = (md != 2'd0);
    assign tk  = (md == 2'd1) ? tick[0] :
                 (md == 2'd2) ? tick[1] :
                 (md == 2'd3) ? tick[2] : 1'b0;
    assign hit = lvl ? (run == CW'(RUN_LEN)) : (s3[i] & ~s2[i]);
    assign clr_ok = wr_en & ~wdata[FB+i] & armed[i] & (~lvl | hi_seen[i]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                         run <= '0;
      else if (!lvl)                      run <= '0;
      else if (tk && s2[i])               run <= '0;
      else if (tk && run != CW'(RUN_LEN)) run <= run + 1'b1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)             hi_seen[i] <= 1'b0;
      else if (rd_en)         hi_seen[i] <= 1'b0;
      else if (tk && s2[i])   hi_seen[i] <= 1'b1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      armed[i] <= 1'b0;
      else if (wr_en)  armed[i] <= 1'b0;
      else if (rd_en)  armed[i] <= flag[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      flag[i] <= 1'b0;
      else if (hit)    flag[i] <= 1'b1;
      else if (clr_ok) flag[i] <= 1'b0;
  end

  assign rdata   = {flag, 3'b000, ie, modes};
  assign hiz_req = |flag;
  assign irq     = ie & hiz_req;
endmodule

module pin_disable_detect_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic        irq,
  input logic        hiz_req,
  input logic [3:0]  flag,
  input logic [3:0]  armed
);
  p_irq_implies_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> hiz_req);

  p_mode_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[8:0] == $past(wdata[8:0])));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((rdata[15:12] & $past(rdata[15:12])) == $past(rdata[15:12])));

  p_keep_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag & ~armed)) |=> ((flag & $past(flag & ~armed)) == $past(flag & ~armed)));

  p_one_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wdata[15:12] & rdata[15:12]) != 4'd0)
      |=> ((rdata[15:12] & $past(wdata[15:12] & rdata[15:12])) == $past(wdata[15:12] & rdata[15:12])));
endmodule

bind pin_disable_detect pin_disable_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .irq(irq), .hiz_req(hiz_req), .flag(flag), .armed(armed)
);

// File: tb/sim_pin_disable_detect.sv
`timescale 1ns/1ps
module sim_pin_disable_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req_n = 4'hF;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, hiz_req;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;
  logic [7:0] sh_modes = '0;
  logic       sh_ie = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  pin_disable_detect u0 (.clk(clk), .rst_n(rst_n), .req_n(req_n), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq), .hiz_req(hiz_req));

  function automatic int div_of(input logic [1:0] m);
    return (m == 2'd1) ? 8 : (m == 2'd2) ? 16 : (m == 2'd3) ? 128 : 1;
  endfunction

  function automatic bit exp_accept(input logic [1:0] m, input int len);
    if (m == 2'd0) return len >= 3;
    return len >= 17 * div_of(m);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(output logic [15:0] d);
    @(negedge clk); #1 d = rdata;
  endtask

  task automatic do_read(output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] f);
    @(negedge clk); wr_en = 1'b1; wdata = {f, 3'b000, sh_ie, sh_modes};
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'd1234));
    waitc(3);
    rst_n = 1'b1;
    peek(d);
    chk("R1 reset rdata", d, 16'h0000);
    chk("R1 reset irq/hiz", {14'd0, irq, hiz_req}, 16'd0);

    sh_modes = 8'hFF; sh_ie = 1'b1;
    do_write(4'hF);
    peek(d);
    chk("R8/R6 write all ones", d, 16'h01FF);
    chk("R7 no flag no hiz", {15'd0, hiz_req}, 16'd0);
    sh_modes = 8'h00; sh_ie = 1'b0;
    do_write(4'h0);
    peek(d);
    chk("R8 cleared readback", d, 16'h0000);

    // R2 edge set, clear while low, rising edge ignored
    @(negedge clk); req_n[1] = 1'b0;
    waitc(6);
    peek(d);
    chk("R2 falling edge sets flag1", d[15:12], 4'b0010);
    chk("R7 hiz with ie off, irq low", {14'd0, irq, hiz_req}, 16'd1);
    do_read(d);
    do_write(4'h0);
    peek(d);
    chk("R4 edge-mode clear while low", d[15:12], 4'b0000);
    req_n[1] = 1'b1;
    waitc(8);
    peek(d);
    chk("R2 rising edge ignored", d[15:12], 4'b0000);

    // R4 / R6 two-step clear sequence
    @(negedge clk); req_n[0] = 1'b0; waitc(5); req_n[0] = 1'b1; waitc(5);
    do_write(4'h0);
    peek(d);
    chk("R4 write 0 without read keeps flag", d[15:12], 4'b0001);
    do_read(d);
    do_write(4'h1);
    peek(d);
    chk("R6 write 1 keeps flag", d[15:12], 4'b0001);
    do_write(4'h0);
    peek(d);
    chk("R4 arm consumed by earlier write", d[15:12], 4'b0001);
    do_read(d);
    do_write(4'h0);
    peek(d);
    chk("R4 read then write 0 clears", d[15:12], 4'b0000);

    // R5 high sample required in filtered mode
    sh_modes = 8'b00_11_00_00;
    do_write(4'h0);
    @(negedge clk); req_n[2] = 1'b0;
    waitc(17 * 128 + 20);
    req_n[2] = 1'b1;
    waitc(300);
    peek(d);
    chk("R3 mode3 long low sets flag2", d[15:12], 4'b0100);
    while ((cyc % 128) != 10) @(negedge clk);
    do_read(d);
    do_write(4'h0);
    peek(d);
    chk("R5 clear blocked before high sample", d[15:12], 4'b0100);
    do_read(d);
    waitc(300);
    do_write(4'h0);
    peek(d);
    chk("R5 clear after high sample", d[15:12], 4'b0000);

    // R9 held-low request wins over clear
    sh_modes = 8'b01_00_00_00; sh_ie = 1'b1;
    do_write(4'h0);
    @(negedge clk); req_n[3] = 1'b0;
    waitc(17 * 8 + 20);
    do_read(d);
    chk("R9 flag3 set while held low", d[15:12], 4'b1000);
    chk("R7 irq with ie on", {14'd0, irq, hiz_req}, 16'd3);
    waitc(30);
    do_write(4'h0);
    peek(d);
    chk("R9 held request beats clear", d[15:12], 4'b1000);
    req_n[3] = 1'b1;
    waitc(40);
    do_read(d);
    waitc(40);
    do_write(4'h0);
    peek(d);
    chk("R9 clear after release", d[15:12], 4'b0000);

    // R3 random trials over all modes
    for (int t = 0; t < 20; t++) begin
      int ch, len, dv;
      logic [1:0] m;
      logic [3:0] ef;
      ch = int'($urandom % 4);
      m  = 2'($urandom % 4);
      dv = div_of(m);
      sh_modes = $urandom;
      sh_modes[2*ch +: 2] = m;
      sh_ie = 1'($urandom % 2);
      do_write(4'h0);
      waitc(300);
      if (m == 2'd0) len = 3 + int'($urandom % 10);
      else if ($urandom % 2) len = 17 * dv + int'($urandom % dv);
      else len = 4 + int'($urandom % (15 * dv - 4));
      @(negedge clk); req_n[ch] = 1'b0;
      waitc(len);
      req_n[ch] = 1'b1;
      waitc(8);
      ef = '0;
      ef[ch] = exp_accept(m, len);
      peek(d);
      chk($sformatf("R3 trial %0d mode %0d len %0d", t, m, len), d[15:12], ef);
      chk("R7 irq/hiz after trial", {14'd0, irq, hiz_req}, {14'd0, sh_ie & (|ef), |ef});
      chk("R8 modes readback", d[8:0], {sh_ie, sh_modes});
      do_read(d);
      waitc(300);
      do_write(4'h0);
      peek(d);
      chk("R4 trial clear", d[15:12], 4'h0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule